// File: doc/BRIEF.md
# Dual-Core Mailbox Interrupt Register File

This block is a register file shared by two processors, a low-power one and a high-performance one. It holds a bank of message words that either side can write and read. Each processor reaches the block through its own synchronous register port, which carries an address, a write enable, write data and read data. Writing a message word flags that word to both processors. This lets one side leave a value for the other and ring its doorbell with a single store.

Each side has four registers of its own: a set of raw flags, a write-one-to-clear mask, an enable mask and a masked status. Bit i of each of these registers stands for message word i. Each side drives one level-sensitive interrupt line, which is high while any of its enabled flags is pending. The map has one entry per word offset and is the same on both ports:

- 0 to 15: message words
- 16: raw flags
- 17: clear
- 18: enable
- 19: status
- 20 to 31: unmapped

Top module: `mbox_irq_regfile`

## Requirements
- R1: After reset, every message word, every raw bit and every enable bit is zero, both interrupt outputs are low and both read data outputs are zero.
- R2: A write to word offset 0..15 on either port stores the data in that message word. Either port can read any message word back.
  - Read data appears on the clock edge after the address is presented, so the port's read data output updates at that edge and is valid in the following cycle.
  - A read in the same cycle as a write to the same word returns the value held before that write.
- R3: A write to message word i from either port sets bit i of the low-power raw flags and bit i of the high-performance raw flags. This holds whichever port did the write. Raw flags are read at offset 16.
- R4: Writing a mask to offset 17 (clear) clears the raw bits of that port's own side wherever the mask has a 1. The other side's raw bits are left alone.
- R5: If a raw bit is set by a message write and cleared through offset 17 in the same cycle, the bit ends up set.
- R6: Offset 18 (enable) is readable and writable per side. Bit i enables message word i, and only the low 16 bits are kept.
- R7: Offset 19 (status) reads as that side's raw bits ANDed with its enable bits.
- R8: Each side's interrupt output is high exactly when its status is non-zero.
- R9: When both ports write the same message word in the same cycle, the high-performance port's data is stored. The raw bit is still set on both sides.
- R10: Reads of offsets 17 and 20..31 return zero. Writes to offsets 16, 19 and 20..31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_addr | input | 5 | Low-power port word offset |
| lp_we | input | 1 | Low-power port write enable |
| lp_wdata | input | 32 | Low-power port write data |
| lp_rdata | output | 32 | Low-power port read data, registered |
| hp_addr | input | 5 | High-performance port word offset |
| hp_we | input | 1 | High-performance port write enable |
| hp_wdata | input | 32 | High-performance port write data |
| hp_rdata | output | 32 | High-performance port read data, registered |
| lp_irq | output | 1 | Low-power side interrupt |
| hp_irq | output | 1 | High-performance side interrupt |

## Verification
Read data is due one clock edge after its address. The bench therefore captures its expected read value from the model state before that edge, and compares it just after the edge. Raw, enable and message updates also land on that same edge, so a write's effect appears in a read issued in the next cycle or later. The interrupt outputs follow the updated raw and enable registers combinationally, and they are compared in that same post-edge window against the model after its update.

// File: rtl/mbox_irq_regfile.sv
module mbox_irq_regfile #(
  parameter int NUM_MSG = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lp_addr,
  input  logic              lp_we,
  input  logic [DATA_W-1:0] lp_wdata,
  output logic [DATA_W-1:0] lp_rdata,
  input  logic [ADDR_W-1:0] hp_addr,
  input  logic              hp_we,
  input  logic [DATA_W-1:0] hp_wdata,
  output logic [DATA_W-1:0] hp_rdata,
  output logic              lp_irq,
  output logic              hp_irq
);
  localparam logic [ADDR_W-1:0] RAW_OFS = ADDR_W'(NUM_MSG);
  localparam logic [ADDR_W-1:0] CLR_OFS = ADDR_W'(NUM_MSG + 1);
  localparam logic [ADDR_W-1:0] ENA_OFS = ADDR_W'(NUM_MSG + 2);
  localparam logic [ADDR_W-1:0] STS_OFS = ADDR_W'(NUM_MSG + 3);

  logic [DATA_W-1:0]  msg_q [NUM_MSG];
  logic [NUM_MSG-1:0] lp_raw_q, hp_raw_q, lp_ena_q, hp_ena_q;
  logic [NUM_MSG-1:0] set_vec, lp_clr, hp_clr;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MSG; gi++) begin : g_slot
      wire lp_hit = lp_we && (lp_addr == ADDR_W'(gi));
      wire hp_hit = hp_we && (hp_addr == ADDR_W'(gi));
      assign set_vec[gi] = lp_hit | hp_hit;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      msg_q[gi] <= '0;
        else if (hp_hit) msg_q[gi] <= hp_wdata;
        else if (lp_hit) msg_q[gi] <= lp_wdata;
    end
  endgenerate

  assign lp_clr = (lp_we && lp_addr == CLR_OFS) ? lp_wdata[NUM_MSG-1:0] : '0;
  assign hp_clr = (hp_we && hp_addr == CLR_OFS) ? hp_wdata[NUM_MSG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lp_raw_q <= '0;
      hp_raw_q <= '0;
      lp_ena_q <= '0;
      hp_ena_q <= '0;
    end else begin
      lp_raw_q <= (lp_raw_q & ~lp_clr) | set_vec;
      hp_raw_q <= (hp_raw_q & ~hp_clr) | set_vec;
      if (lp_we && lp_addr == ENA_OFS) lp_ena_q <= lp_wdata[NUM_MSG-1:0];
      if (hp_we && hp_addr == ENA_OFS) hp_ena_q <= hp_wdata[NUM_MSG-1:0];
    end

  function automatic logic [DATA_W-1:0] read_word(input logic [ADDR_W-1:0] a,
                                                 input logic [NUM_MSG-1:0] raw,
                                                 input logic [NUM_MSG-1:0] ena);
    logic [DATA_W-1:0] r;
    r = '0;
    if (a < RAW_OFS)       r = msg_q[a[$clog2(NUM_MSG)-1:0]];
    else if (a == RAW_OFS) r = DATA_W'(raw);
    else if (a == ENA_OFS) r = DATA_W'(ena);
    else if (a == STS_OFS) r = DATA_W'(raw & ena);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lp_rdata <= '0;
      hp_rdata <= '0;
    end else begin
      lp_rdata <= read_word(lp_addr, lp_raw_q, lp_ena_q);
      hp_rdata <= read_word(hp_addr, hp_raw_q, hp_ena_q);
    end

  assign lp_irq = |(lp_raw_q & lp_ena_q);
  assign hp_irq = |(hp_raw_q & hp_ena_q);
endmodule

// File: rtl/mbox_irq_regfile_chk.sv
module mbox_irq_regfile_chk #(
  parameter int NUM_MSG = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  lp_addr,
  input logic               lp_we,
  input logic [DATA_W-1:0]  lp_rdata,
  input logic [ADDR_W-1:0]  hp_addr,
  input logic               hp_we,
  input logic [DATA_W-1:0]  hp_rdata,
  input logic               lp_irq,
  input logic               hp_irq,
  input logic [NUM_MSG-1:0] lp_raw_q,
  input logic [NUM_MSG-1:0] hp_raw_q,
  input logic [NUM_MSG-1:0] lp_ena_q,
  input logic [NUM_MSG-1:0] hp_ena_q
);
  localparam int IDX_W = $clog2(NUM_MSG);
  localparam logic [ADDR_W-1:0] CLR_OFS = ADDR_W'(NUM_MSG + 1);
  localparam logic [ADDR_W-1:0] ENA_OFS = ADDR_W'(NUM_MSG + 2);
  localparam logic [ADDR_W-1:0] FREE_OFS = ADDR_W'(NUM_MSG + 4);

  AST_LP_WRITE_RINGS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_we && lp_addr < ADDR_W'(NUM_MSG)) |=> (lp_raw_q[$past(lp_addr[IDX_W-1:0])] && hp_raw_q[$past(lp_addr[IDX_W-1:0])])); // R3
  AST_HP_WRITE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_we && hp_addr < ADDR_W'(NUM_MSG)) |=> (lp_raw_q[$past(hp_addr[IDX_W-1:0])] && hp_raw_q[$past(hp_addr[IDX_W-1:0])])); // R5
  AST_HP_RAW_KEPT_WITHOUT_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(hp_we && hp_addr == CLR_OFS) |=> ((hp_raw_q & $past(hp_raw_q)) == $past(hp_raw_q))); // R4
  AST_LP_RAW_KEPT_WITHOUT_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_we && lp_addr == CLR_OFS) |=> ((lp_raw_q & $past(lp_raw_q)) == $past(lp_raw_q))); // R4
  AST_LP_ENA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_we && lp_addr == ENA_OFS) |=> $stable(lp_ena_q)); // R6
  AST_HP_ENA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(hp_we && hp_addr == ENA_OFS) |=> $stable(hp_ena_q)); // R6
  AST_LP_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    lp_irq |-> (lp_raw_q != '0 && lp_ena_q != '0)); // R8
  AST_HP_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    hp_irq |-> (hp_raw_q != '0 && hp_ena_q != '0)); // R8
  AST_LP_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_addr >= FREE_OFS || lp_addr == CLR_OFS) |=> lp_rdata == '0); // R10
  AST_HP_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_addr >= FREE_OFS || hp_addr == CLR_OFS) |=> hp_rdata == '0); // R10
endmodule

bind mbox_irq_regfile mbox_irq_regfile_chk #(.NUM_MSG(NUM_MSG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lp_addr(lp_addr), .lp_we(lp_we), .lp_rdata(lp_rdata),
  .hp_addr(hp_addr), .hp_we(hp_we), .hp_rdata(hp_rdata),
  .lp_irq(lp_irq), .hp_irq(hp_irq),
  .lp_raw_q(lp_raw_q), .hp_raw_q(hp_raw_q), .lp_ena_q(lp_ena_q), .hp_ena_q(hp_ena_q)
);

// File: tb/mbox_irq_regfile_tb_top.sv
module mbox_irq_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  lp_addr = '0, hp_addr = '0;
  logic        lp_we = 1'b0, hp_we = 1'b0;
  logic [31:0] lp_wdata = '0, hp_wdata = '0;
  logic [31:0] lp_rdata, hp_rdata;
  logic        lp_irq, hp_irq;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_msg [16];
  logic [15:0] m_lraw, m_hraw, m_lena, m_hena;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_irq_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .lp_addr(lp_addr), .lp_we(lp_we), .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
    .hp_addr(hp_addr), .hp_we(hp_we), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
    .lp_irq(lp_irq), .hp_irq(hp_irq)
  );

  function automatic logic [31:0] model_rd(input logic [4:0] a, input logic [15:0] raw, input logic [15:0] ena);
    if (a < 16) return m_msg[a[3:0]];
    if (a == 16) return {16'h0, raw};
    if (a == 18) return {16'h0, ena};
    if (a == 19) return {16'h0, raw & ena};
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    if (a < 16) return "R2";
    if (a == 16) return "R3";
    if (a == 18) return "R6";
    if (a == 19) return "R7";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] la, input logic lw, input logic [31:0] ld,
                      input logic [4:0] ha, input logic hw, input logic [31:0] hd,
                      input string tag);
    logic [31:0] el, eh;
    logic [15:0] setv, lclr, hclr;
    @(negedge clk);
    lp_addr = la; lp_we = lw; lp_wdata = ld;
    hp_addr = ha; hp_we = hw; hp_wdata = hd;
    el = model_rd(la, m_lraw, m_lena);
    eh = model_rd(ha, m_hraw, m_hena);
    setv = '0;
    if (lw && la < 16) begin setv[la[3:0]] = 1'b1; m_msg[la[3:0]] = ld; end
    if (hw && ha < 16) begin setv[ha[3:0]] = 1'b1; m_msg[ha[3:0]] = hd; end
    lclr = (lw && la == 17) ? ld[15:0] : 16'h0;
    hclr = (hw && ha == 17) ? hd[15:0] : 16'h0;
    m_lraw = (m_lraw & ~lclr) | setv;
    m_hraw = (m_hraw & ~hclr) | setv;
    if (lw && la == 18) m_lena = ld[15:0];
    if (hw && ha == 18) m_hena = hd[15:0];
    @(posedge clk);
    #1;
    check(tag == "" ? tag_of(la) : tag, lp_rdata, el);
    check(tag == "" ? tag_of(ha) : tag, hp_rdata, eh);
    check("R8", {31'h0, lp_irq}, {31'h0, |(m_lraw & m_lena)});
    check("R8", {31'h0, hp_irq}, {31'h0, |(m_hraw & m_hena)});
    lp_we = 1'b0; hp_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 16; i++) m_msg[i] = '0;
    m_lraw = '0; m_hraw = '0; m_lena = '0; m_hena = '0;
    #(CLK_PERIOD * 3 + 2);
    check("R1", lp_rdata, 32'h0);
    check("R1", {31'h0, lp_irq | hp_irq}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) step(5'(i), 1'b0, 0, 5'(19 - i), 1'b0, 0, "R1");

    // R2 write from low-power side, read from both; read-during-write returns old
    step(5'd3, 1'b1, 32'hA5A5_0003, 5'd3, 1'b0, 0, "R2");
    step(5'd3, 1'b0, 0, 5'd3, 1'b0, 0, "R2");
    step(5'd3, 1'b0, 0, 5'd3, 1'b1, 32'h1234_5678, "R2");
    step(5'd3, 1'b0, 0, 5'd3, 1'b0, 0, "R2");
    // R3 high-performance write rings both sides
    step(5'd9, 1'b0, 0, 5'd7, 1'b1, 32'h0000_0077, "R3");
    step(5'd16, 1'b0, 0, 5'd16, 1'b0, 0, "R3");
    // R6 enable read-back, R7 status, R8 irq
    step(5'd18, 1'b1, 32'hFFFF_0088, 5'd18, 1'b1, 32'h0000_0008, "R6");
    step(5'd18, 1'b0, 0, 5'd18, 1'b0, 0, "R6");
    step(5'd19, 1'b0, 0, 5'd19, 1'b0, 0, "R7");
    // R4 clear on own side only
    step(5'd17, 1'b1, 32'h0000_0008, 5'd16, 1'b0, 0, "R4");
    step(5'd16, 1'b0, 0, 5'd16, 1'b0, 0, "R4");
    // R5 set beats clear in the same cycle
    step(5'd17, 1'b1, 32'h0000_0080, 5'd7, 1'b1, 32'hBEEF_0007, "R5");
    step(5'd16, 1'b0, 0, 5'd16, 1'b0, 0, "R5");
    // R9 both write same word
    step(5'd5, 1'b1, 32'h1111_1111, 5'd5, 1'b1, 32'h2222_2222, "R9");
    step(5'd5, 1'b0, 0, 5'd16, 1'b0, 0, "R9");
    // R10 writes to read-only and unmapped offsets ignored
    step(5'd16, 1'b1, 32'hFFFF_FFFF, 5'd19, 1'b1, 32'hFFFF_FFFF, "R10");
    step(5'd25, 1'b1, 32'hFFFF_FFFF, 5'd31, 1'b1, 32'hFFFF_FFFF, "R10");
    step(5'd16, 1'b0, 0, 5'd17, 1'b0, 0, "R10");
    step(5'd25, 1'b0, 0, 5'd19, 1'b0, 0, "R10");

    for (int k = 0; k < 4000; k++) begin
      logic [4:0] la, ha;
      la = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(16, 31)) : 5'($urandom_range(0, 15));
      ha = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(16, 31)) : 5'($urandom_range(0, 15));
      step(la, 1'($urandom_range(0, 1)), $urandom, ha, 1'($urandom_range(0, 1)), $urandom, "");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule